// File: doc/BRIEF.md
# PLL Configuration and Lock-Monitor Register File

This block is an APB slave that sits between software and an external analog clock synthesizer. It holds the synthesizer's settings: the input reference divider, the integer feedback divider, two cascaded output post-dividers, a reference bypass select and four power-down controls. It drives every setting out as a static level that stays put until software writes it again.

The lock indication from the synthesizer arrives from a foreign clock domain. The block passes it through a two-flop synchronizer and shows it in the control word. A falling edge of the synchronized lock sets two sticky loss-of-lock flags. One sits in the control word and the other is the raw interrupt source. Software clears each flag by writing a one to its bit. The raw flag feeds a single-source interrupt set with enable, force and masked status, and the status drives a registered `irq` pin.

A combinational `configValid` output tells whether the current divider settings lie within the range the synthesizer accepts.

Top module: `pll_cfg_regs`

## Requirements
- R1: After reset, reads return these values: 0x00 = 0x00000001 (with the lock input low), 0x04 = 0x0000002D, 0x08 = 0, 0x0C = 0x00077000, and 0x10, 0x14, 0x18 and 0x1C all 0.
- R2: The writable fields are listed here, and they read back what was written. At 0x00 they are the reference divider (bits 5:0) and bypass (bit 8). At 0x04 they are the power-downs: VCO at bit 5, post-divider at bit 3, modulator at bit 2 and main at bit 0. At 0x08 it is the feedback divider (bits 11:0). At 0x0C they are postdiv1 (bits 18:16) and postdiv2 (bits 14:12). At 0x14 it is the interrupt enable (bit 0), and at 0x18 it is the interrupt force (bit 0). Every other bit reads 0.
- R3: Writes to the lock bit (0x00 bit 31) and to the status word (0x1C) have no effect.
- R4: Bit 31 at 0x00 shows the lock input after a two-flop synchronizer.
- R5: A 1-to-0 change of the synchronized lock sets 0x00 bit 30 and 0x10 bit 0. Each flag stays set until a one is written to its own bit position. Writing a zero there leaves the flag set.
- R6: The status word at 0x1C, bit 0, equals (raw AND enable) OR force.
- R7: `irq` equals the status bit delayed by one clock.
- R8: `configValid` is 1 exactly when the reference divider is nonzero and the feedback divider is between 16 and 320 inclusive.
- R9: `pReady` is always 1. An access to an offset above 0x1C raises `pSlvErr`, reads 0 and changes no state.
- R10: The divider, bypass and power-down outputs follow their register fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pClk | input | 1 | APB clock |
| pResetN | input | 1 | Asynchronous active-low reset |
| pSel | input | 1 | APB select |
| pEnable | input | 1 | APB access phase |
| pWrite | input | 1 | APB write |
| pAddr | input | ADDR_W | Byte address |
| pWdata | input | 32 | Write data |
| pRdata | output | 32 | Read data |
| pReady | output | 1 | Transfer ready, tied high |
| pSlvErr | output | 1 | Out-of-range access error |
| pllLockAsync | input | 1 | Lock indication from the synthesizer, asynchronous |
| refDiv | output | REFDIV_W | Reference divider |
| fbDiv | output | FBDIV_W | Feedback divider |
| postDiv1 | output | POSTDIV_W | First post-divider |
| postDiv2 | output | POSTDIV_W | Second post-divider |
| bypass | output | 1 | Reference bypass select |
| pwrDown | output | 1 | Main power-down |
| vcoPwrDown | output | 1 | VCO power-down |
| postDivPwrDown | output | 1 | Post-divider power-down |
| dsmPwrDown | output | 1 | Modulator power-down |
| configValid | output | 1 | Divider settings in range |
| irq | output | 1 | Registered interrupt |

## Verification
The range check is swept over every feedback value from 0 to 340 with three reference divider values: zero, one and the all-ones value. This separates off-by-one errors at 15/16 and 320/321 from errors in the zero test on the reference divider. All eight combinations of raw, enable and force are applied to the interrupt path. This separates the AND term from the OR term and catches a wrong delay on `irq`. The lock input is toggled to check the synchronizer latency and the set-over-hold behaviour of the sticky flags. Writes of zero and of one to the clear bits show that only a one clears a flag.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  // register index = byte offset / 4
  localparam int IDX_CS    = 0;
  localparam int IDX_PWR   = 1;
  localparam int IDX_FB    = 2;
  localparam int IDX_PRIM  = 3;
  localparam int IDX_RAW   = 4;
  localparam int IDX_EN    = 5;
  localparam int IDX_FORCE = 6;
  localparam int IDX_STAT  = 7;

  // bit positions software decodes
  localparam int CS_LOCK_BIT   = 31;
  localparam int CS_LOCKN_BIT  = 30;
  localparam int CS_BYP_BIT    = 8;
  localparam int PWR_VCO_BIT   = 5;
  localparam int PWR_POST_BIT  = 3;
  localparam int PWR_DSM_BIT   = 2;
  localparam int PWR_MAIN_BIT  = 0;
  localparam int PRIM_PD1_LSB  = 16;
  localparam int PRIM_PD2_LSB  = 12;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrStb;  // one-hot write strobe per register
    logic [IDX_W-1:0]    idx;    // read select
    logic                hit;    // in-range access phase
  } regStrobe_t;
endpackage

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  output regStrobe_t        stb,
  output logic              pSlvErr
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(NUM_REGS - 1);

  logic [WORD_W-1:0] word;
  logic access;
  logic inRange;

  assign word    = pAddr[ADDR_W-1:2];
  assign access  = pSel & pEnable;
  assign inRange = (word <= LAST_WORD);

  assign stb.hit = access & inRange;
  assign stb.idx = word[IDX_W-1:0];
  assign pSlvErr = access & ~inRange;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_stb
    assign stb.wrStb[i] = access & pWrite & (word == WORD_W'(i));
  end
endmodule

// File: rtl/pll_cfg_dp.sv
module pll_cfg_dp
  import pll_cfg_pkg::*;
#(
  parameter int REFDIV_W  = 6,
  parameter int FBDIV_W   = 12,
  parameter int POSTDIV_W = 3,
  parameter int FB_MIN    = 16,
  parameter int FB_MAX    = 320
) (
  input  logic                 pClk,
  input  logic                 pResetN,
  input  regStrobe_t           stb,
  input  logic [31:0]          pWdata,
  input  logic                 pllLockAsync,
  output logic [31:0]          pRdata,
  output logic [REFDIV_W-1:0]  refDiv,
  output logic [FBDIV_W-1:0]   fbDiv,
  output logic [POSTDIV_W-1:0] postDiv1,
  output logic [POSTDIV_W-1:0] postDiv2,
  output logic                 bypass,
  output logic                 pwrDown,
  output logic                 vcoPwrDown,
  output logic                 postDivPwrDown,
  output logic                 dsmPwrDown,
  output logic                 configValid,
  output logic                 irq,
  output logic                 lockSync,
  output logic                 csLockN,
  output logic                 rawFlag,
  output logic                 intStatus
);
  localparam logic [FBDIV_W-1:0] FB_LO = FBDIV_W'(FB_MIN);
  localparam logic [FBDIV_W-1:0] FB_HI = FBDIV_W'(FB_MAX);

  logic lockMeta, lockSyncD, lockFall;
  logic intEn, intForce;

  // lock synchronizer and fall detect
  always_ff @(posedge pClk or negedge pResetN) begin
    if (!pResetN) begin
      lockMeta  <= 1'b0;
      lockSync  <= 1'b0;
      lockSyncD <= 1'b0;
    end else begin
      lockMeta  <= pllLockAsync;
      lockSync  <= lockMeta;
      lockSyncD <= lockSync;
    end
  end
  assign lockFall = lockSyncD & ~lockSync;

  // configuration fields
  always_ff @(posedge pClk or negedge pResetN) begin
    if (!pResetN) begin
      refDiv         <= REFDIV_W'(1);
      bypass         <= 1'b0;
      fbDiv          <= '0;
      postDiv1       <= '1;
      postDiv2       <= '1;
      pwrDown        <= 1'b1;
      vcoPwrDown     <= 1'b1;
      postDivPwrDown <= 1'b1;
      dsmPwrDown     <= 1'b1;
      intEn          <= 1'b0;
      intForce       <= 1'b0;
    end else begin
      if (stb.wrStb[IDX_CS]) begin
        refDiv <= pWdata[REFDIV_W-1:0];
        bypass <= pWdata[CS_BYP_BIT];
      end
      if (stb.wrStb[IDX_PWR]) begin
        pwrDown        <= pWdata[PWR_MAIN_BIT];
        vcoPwrDown     <= pWdata[PWR_VCO_BIT];
        postDivPwrDown <= pWdata[PWR_POST_BIT];
        dsmPwrDown     <= pWdata[PWR_DSM_BIT];
      end
      if (stb.wrStb[IDX_FB]) fbDiv <= pWdata[FBDIV_W-1:0];
      if (stb.wrStb[IDX_PRIM]) begin
        postDiv1 <= pWdata[PRIM_PD1_LSB +: POSTDIV_W];
        postDiv2 <= pWdata[PRIM_PD2_LSB +: POSTDIV_W];
      end
      if (stb.wrStb[IDX_EN])    intEn    <= pWdata[0];
      if (stb.wrStb[IDX_FORCE]) intForce <= pWdata[0];
    end
  end

  // sticky flags: set wins over clear
  always_ff @(posedge pClk or negedge pResetN) begin
    if (!pResetN) begin
      csLockN <= 1'b0;
      rawFlag <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (lockFall)                                      csLockN <= 1'b1;
      else if (stb.wrStb[IDX_CS] && pWdata[CS_LOCKN_BIT]) csLockN <= 1'b0;
      if (lockFall)                                rawFlag <= 1'b1;
      else if (stb.wrStb[IDX_RAW] && pWdata[0])    rawFlag <= 1'b0;
      irq <= intStatus;
    end
  end

  assign intStatus   = (rawFlag & intEn) | intForce;
  assign configValid = (refDiv != '0) && (fbDiv >= FB_LO) && (fbDiv <= FB_HI);

  // read mux
  logic [31:0] rdMux;
  always_comb begin
    rdMux = '0;
    unique case (stb.idx)
      IDX_W'(IDX_CS): begin
        rdMux[REFDIV_W-1:0] = refDiv;
        rdMux[CS_BYP_BIT]   = bypass;
        rdMux[CS_LOCKN_BIT] = csLockN;
        rdMux[CS_LOCK_BIT]  = lockSync;
      end
      IDX_W'(IDX_PWR): begin
        rdMux[PWR_MAIN_BIT] = pwrDown;
        rdMux[PWR_VCO_BIT]  = vcoPwrDown;
        rdMux[PWR_POST_BIT] = postDivPwrDown;
        rdMux[PWR_DSM_BIT]  = dsmPwrDown;
      end
      IDX_W'(IDX_FB):    rdMux[FBDIV_W-1:0] = fbDiv;
      IDX_W'(IDX_PRIM): begin
        rdMux[PRIM_PD1_LSB +: POSTDIV_W] = postDiv1;
        rdMux[PRIM_PD2_LSB +: POSTDIV_W] = postDiv2;
      end
      IDX_W'(IDX_RAW):   rdMux[0] = rawFlag;
      IDX_W'(IDX_EN):    rdMux[0] = intEn;
      IDX_W'(IDX_FORCE): rdMux[0] = intForce;
      default:           rdMux[0] = intStatus;
    endcase
  end
  assign pRdata = stb.hit ? rdMux : 32'h0;
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REFDIV_W  = 6,
  parameter int FBDIV_W   = 12,
  parameter int POSTDIV_W = 3,
  parameter int FB_MIN    = 16,
  parameter int FB_MAX    = 320
) (
  input  logic                 pClk,
  input  logic                 pResetN,
  input  logic                 pSel,
  input  logic                 pEnable,
  input  logic                 pWrite,
  input  logic [ADDR_W-1:0]    pAddr,
  input  logic [31:0]          pWdata,
  output logic [31:0]          pRdata,
  output logic                 pReady,
  output logic                 pSlvErr,
  input  logic                 pllLockAsync,
  output logic [REFDIV_W-1:0]  refDiv,
  output logic [FBDIV_W-1:0]   fbDiv,
  output logic [POSTDIV_W-1:0] postDiv1,
  output logic [POSTDIV_W-1:0] postDiv2,
  output logic                 bypass,
  output logic                 pwrDown,
  output logic                 vcoPwrDown,
  output logic                 postDivPwrDown,
  output logic                 dsmPwrDown,
  output logic                 configValid,
  output logic                 irq
);
  regStrobe_t stb;
  logic lockSync, csLockN, rawFlag, intStatus;

  assign pReady = 1'b1;

  pll_cfg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite), .pAddr(pAddr),
    .stb(stb), .pSlvErr(pSlvErr)
  );

  pll_cfg_dp #(
    .REFDIV_W(REFDIV_W), .FBDIV_W(FBDIV_W), .POSTDIV_W(POSTDIV_W),
    .FB_MIN(FB_MIN), .FB_MAX(FB_MAX)
  ) dp_i (
    .pClk(pClk), .pResetN(pResetN), .stb(stb), .pWdata(pWdata),
    .pllLockAsync(pllLockAsync), .pRdata(pRdata),
    .refDiv(refDiv), .fbDiv(fbDiv), .postDiv1(postDiv1), .postDiv2(postDiv2),
    .bypass(bypass), .pwrDown(pwrDown), .vcoPwrDown(vcoPwrDown),
    .postDivPwrDown(postDivPwrDown), .dsmPwrDown(dsmPwrDown),
    .configValid(configValid), .irq(irq),
    .lockSync(lockSync), .csLockN(csLockN), .rawFlag(rawFlag),
    .intStatus(intStatus)
  );
endmodule

// File: rtl/pll_cfg_chk.sv
module pll_cfg_chk #(
  parameter int ADDR_W   = 8,
  parameter int REFDIV_W = 6,
  parameter int FBDIV_W  = 12,
  parameter int FB_MIN   = 16,
  parameter int FB_MAX   = 320
) (
  input logic                pClk,
  input logic                pResetN,
  input logic                pSel,
  input logic                pEnable,
  input logic                pWrite,
  input logic [ADDR_W-1:0]   pAddr,
  input logic [31:0]         pWdata,
  input logic [31:0]         pRdata,
  input logic                pSlvErr,
  input logic                irq,
  input logic                configValid,
  input logic [REFDIV_W-1:0] refDiv,
  input logic [FBDIV_W-1:0]  fbDiv,
  input logic                lockSync,
  input logic                csLockN,
  input logic                rawFlag,
  input logic                intStatus
);
  logic accOob;
  logic clrRaw;
  assign accOob = pSel && pEnable && (pAddr[ADDR_W-1:2] > (ADDR_W-2)'(7));
  assign clrRaw = pSel && pEnable && pWrite && (pAddr[ADDR_W-1:2] == (ADDR_W-2)'(4)) && pWdata[0];

  assert_oob_err_R9: assert property (@(posedge pClk) disable iff (!pResetN)
    accOob |-> (pSlvErr && pRdata == 32'h0));

  assert_oob_nowrite_R9: assert property (@(posedge pClk) disable iff (!pResetN)
    (accOob && pWrite) |=> ($stable(refDiv) && $stable(fbDiv)));

  assert_fall_sets_R5: assert property (@(posedge pClk) disable iff (!pResetN)
    $fell(lockSync) |=> (rawFlag && csLockN));

  assert_raw_holds_R5: assert property (@(posedge pClk) disable iff (!pResetN)
    (rawFlag && !clrRaw) |=> rawFlag);

  assert_irq_delay_R7: assert property (@(posedge pClk) disable iff (!pResetN)
    intStatus |=> irq);

  assert_irq_low_R7: assert property (@(posedge pClk) disable iff (!pResetN)
    !intStatus |=> !irq);

  assert_cfg_range_R8: assert property (@(posedge pClk) disable iff (!pResetN)
    configValid |-> (refDiv != '0 && fbDiv >= FBDIV_W'(FB_MIN) && fbDiv <= FBDIV_W'(FB_MAX)));
endmodule

bind pll_cfg_regs pll_cfg_chk #(
  .ADDR_W(ADDR_W), .REFDIV_W(REFDIV_W), .FBDIV_W(FBDIV_W),
  .FB_MIN(FB_MIN), .FB_MAX(FB_MAX)
) chk_i (
  .pClk(pClk), .pResetN(pResetN), .pSel(pSel), .pEnable(pEnable),
  .pWrite(pWrite), .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata),
  .pSlvErr(pSlvErr), .irq(irq), .configValid(configValid),
  .refDiv(refDiv), .fbDiv(fbDiv), .lockSync(lockSync), .csLockN(csLockN),
  .rawFlag(rawFlag), .intStatus(intStatus)
);

// File: tb/pll_cfg_regs_tb.sv
module pll_cfg_regs_tb_top;
  logic        pClk = 1'b0;
  logic        pResetN = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [7:0]  pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic        pReady, pSlvErr;
  logic        pllLockAsync = 1'b0;
  logic [5:0]  refDiv;
  logic [11:0] fbDiv;
  logic [2:0]  postDiv1, postDiv2;
  logic        bypass, pwrDown, vcoPwrDown, postDivPwrDown, dsmPwrDown;
  logic        configValid, irq;

  int nChk = 0;
  int nErr = 0;
  bit done = 0;

  always #4 pClk = ~pClk;

  pll_cfg_regs dut_i (
    .pClk(pClk), .pResetN(pResetN), .pSel(pSel), .pEnable(pEnable),
    .pWrite(pWrite), .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata),
    .pReady(pReady), .pSlvErr(pSlvErr), .pllLockAsync(pllLockAsync),
    .refDiv(refDiv), .fbDiv(fbDiv), .postDiv1(postDiv1), .postDiv2(postDiv2),
    .bypass(bypass), .pwrDown(pwrDown), .vcoPwrDown(vcoPwrDown),
    .postDivPwrDown(postDivPwrDown), .dsmPwrDown(dsmPwrDown),
    .configValid(configValid), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d, output logic err);
    @(negedge pClk);
    pSel = 1'b1; pWrite = 1'b1; pAddr = a; pWdata = d;
    @(negedge pClk);
    pEnable = 1'b1;
    #1 err = pSlvErr;
    @(negedge pClk);
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0;
  endtask

  task automatic apbRead(input logic [7:0] a, output logic [31:0] d, output logic err);
    @(negedge pClk);
    pSel = 1'b1; pWrite = 1'b0; pAddr = a;
    @(negedge pClk);
    pEnable = 1'b1;
    #1 begin d = pRdata; err = pSlvErr; end
    @(negedge pClk);
    pSel = 1'b0; pEnable = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic e;
    apbWrite(a, d, e);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic e;
    apbRead(a, d, e);
    chk(req, d, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    nChk++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(negedge pClk);
    pResetN = 1'b1;

    // R1 reset values
    rdChk("R1 cs",    8'h00, 32'h0000_0001);
    rdChk("R1 pwr",   8'h04, 32'h0000_002D);
    rdChk("R1 fb",    8'h08, 32'h0);
    rdChk("R1 prim",  8'h0C, 32'h0007_7000);
    for (int i = 4; i < 8; i++) rdChk("R1 intr", 8'(i * 4), 32'h0);
    chk("R8 reset invalid", {31'b0, configValid}, 32'h0);
    chk("R9 ready", {31'b0, pReady}, 32'h1);

    // R2/R10 masks and outputs
    wr(8'h00, 32'hFFFF_FFFF & ~32'h4000_0000);
    rdChk("R2 cs mask", 8'h00, 32'h0000_013F);
    chk("R10 bypass/ref", {23'b0, bypass, 2'b0, refDiv}, 32'h0000_013F);
    wr(8'h04, 32'h0);
    rdChk("R2 pwr zero", 8'h04, 32'h0);
    chk("R10 pwr zero", {28'b0, vcoPwrDown, postDivPwrDown, dsmPwrDown, pwrDown}, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    rdChk("R2 pwr mask", 8'h04, 32'h0000_002D);
    chk("R10 pwr ones", {28'b0, vcoPwrDown, postDivPwrDown, dsmPwrDown, pwrDown}, 32'hF);
    wr(8'h08, 32'hFFFF_FFFF);
    rdChk("R2 fb mask", 8'h08, 32'h0000_0FFF);
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        wr(8'h0C, 32'((a << 16) | (b << 12)) | 32'hFFF8_8FFF);
        rdChk("R2 prim", 8'h0C, 32'((a << 16) | (b << 12)));
        chk("R10 postdiv", {26'b0, postDiv1, postDiv2}, 32'((a << 3) | b));
      end
    end
    wr(8'h14, 32'hFFFF_FFFF); rdChk("R2 en mask", 8'h14, 32'h1);
    wr(8'h14, 32'h0);
    wr(8'h18, 32'hFFFF_FFFE); rdChk("R2 force mask", 8'h18, 32'h0);

    // R8 range sweep
    for (int r = 0; r < 3; r++) begin
      int rv;
      rv = (r == 0) ? 0 : (r == 1) ? 1 : 63;
      wr(8'h00, 32'(rv));
      for (int f = 0; f <= 340; f++) begin
        wr(8'h08, 32'(f));
        chk("R8 configValid", {31'b0, configValid},
            {31'b0, (rv != 0) && (f >= 16) && (f <= 320)});
      end
    end
    wr(8'h00, 32'h1);

    // R9 out of range
    apbWrite(8'h20, 32'hFFFF_FFFF, e);
    chk("R9 wr err", {31'b0, e}, 32'h1);
    apbRead(8'h24, d, e);
    chk("R9 rd err", {31'b0, e}, 32'h1);
    chk("R9 rd zero", d, 32'h0);
    apbRead(8'hFC, d, e);
    chk("R9 rd err top", {31'b0, e}, 32'h1);
    rdChk("R9 no side effect", 8'h00, 32'h1);
    apbRead(8'h1C, d, e);
    chk("R9 last ok", {31'b0, e}, 32'h0);

    // R4 synchronizer
    @(negedge pClk); pllLockAsync = 1'b1;
    @(posedge pClk); #1;
    @(negedge pClk);
    @(posedge pClk); #1;
    rdChk("R4 lock seen", 8'h00, 32'h8000_0001);
    // R3 read-only
    wr(8'h00, 32'h0000_0001);
    rdChk("R3 lock ro", 8'h00, 32'h8000_0001);

    // R5 sticky on fall
    @(negedge pClk); pllLockAsync = 1'b0;
    repeat (4) @(negedge pClk);
    rdChk("R5 cs sticky", 8'h00, 32'h4000_0001);
    rdChk("R5 raw sticky", 8'h10, 32'h1);
    wr(8'h00, 32'h0000_0001);
    rdChk("R5 zero keeps", 8'h00, 32'h4000_0001);
    wr(8'h00, 32'h4000_0001);
    rdChk("R5 cs cleared", 8'h00, 32'h0000_0001);
    rdChk("R5 raw kept", 8'h10, 32'h1);
    wr(8'h10, 32'h0);
    rdChk("R5 raw zero keeps", 8'h10, 32'h1);

    // R6/R7 all combos of raw/en/force
    for (int c = 0; c < 8; c++) begin
      logic rw, en, fo, st;
      rw = c[0]; en = c[1]; fo = c[2];
      wr(8'h18, 32'h0);
      if (!rw) wr(8'h10, 32'h1);
      else if (!dut_i.pRdata[0]) begin
        @(negedge pClk); pllLockAsync = 1'b1;
        repeat (3) @(negedge pClk);
        pllLockAsync = 1'b0;
        repeat (4) @(negedge pClk);
      end
      wr(8'h14, {31'b0, en});
      // force write: status updates at its commit edge, irq one edge later
      apbWrite(8'h18, {31'b0, fo}, e);
      st = (rw & en) | fo;
      rdChk("R6 status", 8'h1C, {31'b0, st});
      chk("R7 irq", {31'b0, irq}, {31'b0, st});
      wr(8'h1C, 32'h0);
      rdChk("R3 status ro", 8'h1C, {31'b0, st});
    end
    // R7 exact delay
    wr(8'h14, 32'h0); wr(8'h10, 32'h1);
    wr(8'h18, 32'h0);
    apbWrite(8'h18, 32'h1, e);
    chk("R7 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge pClk);
    chk("R7 irq set", {31'b0, irq}, 32'h1);

    finishRun();
  end
endmodule